// File: doc/BRIEF.md
# Missing-Tooth Crank Wheel Generator

This block turns an engine angle into the digital signal of a toothed crank wheel. The wheel has a regular tooth period, made of a high-phase width followed by a low-phase width, both in degrees. A run of consecutive teeth is left out to form a reference gap that an engine controller can lock onto. The angle comes from an external angle source each clock. It is unsigned fixed point with `FRAC_BITS` fractional bits. It counts either crank degrees, wrapping at 360, or full-cycle degrees, wrapping at 720.

The tooth pattern is set entirely in the angle domain. The settings are:
- the high and low widths of a tooth;
- the number of removed teeth;
- where the gap starts;
- a top-dead-center shift of the whole pattern;
- the output polarity;
- the wrap reference.

All settings are sampled as one set, and only when the angle wraps, so a revolution is never drawn with mixed settings. All angles and offsets given to the block must lie below the selected wrap value.

Top module: `crank_wheel_gen`

## Requirements
- R1: While `rst_ni` is low, `tooth_o` is 0.
- R2: With polarity high, no gap and no shift, `tooth_o` is 1 when (angle mod P) < H and 0 otherwise, where H is the high width and P = H + L is the tooth period.
- R3: `tooth_o` is registered. After a rising edge it shows the pattern value for the angle sampled at that edge, and it does not change before the next edge.
- R4: The span of N·P degrees that starts at the gap start is held at the inactive level, where N is the missing-tooth count.
- R5: The gap position is measured as (reference angle − gap start) mod wrap, so moving the gap start moves the gap without moving the teeth.
- R6: With `pol_high_i`=1 the tooth high phase drives 1 and the inactive level is 0. With `pol_high_i`=0 the line is inverted, and the inactive level is 1.
- R7: The pattern is evaluated at the reference angle (angle − TDC shift) mod wrap. A shift larger than the angle wraps around.
- R8: With `cycle_ref_i`=0 the wrap value is 360 degrees. With `cycle_ref_i`=1 it is 720 degrees, and the gap occurs once per 720 degrees.
- R9: The settings are taken from the inputs only at the first rising edge after reset and at any edge where the sampled angle is lower than the angle sampled at the previous edge. At every other edge the held settings are used.
- R10: When H + L is 0, `tooth_o` stays at the inactive level.
- R11: With a missing-tooth count of 0, the output is an uninterrupted periodic tooth train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| angle_i | input | ANG_W | Engine angle, fixed point, below the wrap value |
| cycle_ref_i | input | 1 | 0: wrap at 360 degrees, 1: wrap at 720 degrees |
| high_width_i | input | ANG_W | Tooth high-phase width in degrees |
| low_width_i | input | ANG_W | Tooth low-phase width in degrees |
| gap_teeth_i | input | MISS_W | Number of consecutive teeth removed |
| gap_start_i | input | ANG_W | Angle at which the gap begins |
| tdc_shift_i | input | ANG_W | Shift of the whole pattern against the angle |
| pol_high_i | input | 1 | 1: tooth high phase drives 1, 0: inverted |
| tooth_o | output | 1 | Wheel signal |

## Verification
The bound checker watches four things on every cycle:
- the output level during reset;
- that the held settings do not move unless the angle falls back;
- that the output is steady while the angle is steady;
- that a zero-length period always gives the inactive level.

The tooth shape, the gap span and its position, the top-dead-center shift, the polarity and the wrap select are value-dependent. Only the bench's scenarios can show these, by comparing the output at chosen angles with values worked out by hand from the requirements. The bench also changes settings in the middle of a revolution, to show they wait for the wrap.

// File: rtl/crank_wheel_pkg.sv
`timescale 1ns/1ps
package crank_wheel_pkg;

    // Wrap reference selected by cycle_ref_i
    typedef enum logic {
        REF_CRANK = 1'b0,
        REF_CYCLE = 1'b1
    } ref_sel_e;

    localparam int unsigned DEG_CRANK = 360;
    localparam int unsigned DEG_CYCLE = 720;

    // Bits needed for the integer part of the largest angle
    localparam int unsigned DEG_INT_W = $clog2(DEG_CYCLE);

endpackage

// File: rtl/cwg_mod_sub.sv
`timescale 1ns/1ps
// (a - b) mod wrap, for a and b already below wrap
module cwg_mod_sub #(
    parameter int unsigned W = 14
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] wrap_i,
    output logic [W-1:0] diff_o
);
    always_comb begin
        if (a_i >= b_i) begin
            diff_o = a_i - b_i;
        end else begin
            diff_o = a_i + (wrap_i - b_i);
        end
    end
endmodule

// File: rtl/cwg_cfg_hold.sv
`timescale 1ns/1ps
// Holds the settings for a revolution; reloads at the first edge after
// reset and whenever the angle falls below the previously sampled angle.
module cwg_cfg_hold #(
    parameter int unsigned ANG_W   = 14,
    parameter int unsigned CFG_W   = 64,
    parameter logic [CFG_W-1:0] RST_CFG = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [ANG_W-1:0] angle_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic [CFG_W-1:0] cfg_use_o,
    output logic [CFG_W-1:0] cfg_held_o
);
    typedef struct packed {
        logic             primed;
        logic [ANG_W-1:0] last_ang;
        logic [CFG_W-1:0] cfg;
    } hold_t;

    hold_t hold_d, hold_q;
    logic  load;

    always_comb begin
        hold_d          = hold_q;
        load            = !hold_q.primed || (angle_i < hold_q.last_ang);
        hold_d.primed   = 1'b1;
        hold_d.last_ang = angle_i;
        if (load) begin
            hold_d.cfg = cfg_i;
        end
        cfg_use_o = hold_d.cfg;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hold_q.primed   <= 1'b0;
            hold_q.last_ang <= '0;
            hold_q.cfg      <= RST_CFG;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign cfg_held_o = hold_q.cfg;
endmodule

// File: rtl/cwg_tooth_map.sv
`timescale 1ns/1ps
// Maps a reference angle to "tooth high phase, outside the gap"
module cwg_tooth_map #(
    parameter int unsigned ANG_W  = 14,
    parameter int unsigned MISS_W = 8
) (
    input  logic [ANG_W-1:0]  ref_ang_i,
    input  logic [ANG_W-1:0]  wrap_i,
    input  logic [ANG_W-1:0]  high_i,
    input  logic [ANG_W-1:0]  low_i,
    input  logic [MISS_W-1:0] miss_i,
    input  logic [ANG_W-1:0]  gap_start_i,
    output logic              active_o
);
    localparam int unsigned PER_W = ANG_W + 1;
    localparam int unsigned GAP_W = ANG_W + MISS_W + 1;

    logic [PER_W-1:0] period;
    logic [PER_W-1:0] phase;
    logic [ANG_W-1:0] gap_dist;
    logic [GAP_W-1:0] gap_len;
    logic             in_high;
    logic             in_gap;

    cwg_mod_sub #(.W(ANG_W)) i_gap_sub (
        .a_i    (ref_ang_i),
        .b_i    (gap_start_i),
        .wrap_i (wrap_i),
        .diff_o (gap_dist)
    );

    always_comb begin
        period = {1'b0, high_i} + {1'b0, low_i};
        if (period == '0) begin
            phase   = '0;
            in_high = 1'b0;
        end else begin
            phase   = {1'b0, ref_ang_i} % period;
            in_high = phase < {1'b0, high_i};
        end
        gap_len  = {{(ANG_W + 1){1'b0}}, miss_i} * {{MISS_W{1'b0}}, period};
        in_gap   = {{(MISS_W + 1){1'b0}}, gap_dist} < gap_len;
        active_o = in_high && !in_gap;
    end
endmodule

// File: rtl/crank_wheel_gen.sv
`timescale 1ns/1ps
module crank_wheel_gen
    import crank_wheel_pkg::*;
#(
    parameter int unsigned FRAC_BITS = 4,
    parameter int unsigned MISS_W    = 8,
    localparam int unsigned ANG_W    = DEG_INT_W + FRAC_BITS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ANG_W-1:0]  angle_i,
    input  logic              cycle_ref_i,
    input  logic [ANG_W-1:0]  high_width_i,
    input  logic [ANG_W-1:0]  low_width_i,
    input  logic [MISS_W-1:0] gap_teeth_i,
    input  logic [ANG_W-1:0]  gap_start_i,
    input  logic [ANG_W-1:0]  tdc_shift_i,
    input  logic              pol_high_i,
    output logic              tooth_o
);
    localparam int unsigned CFG_W = 2 + 4 * ANG_W + MISS_W;
    localparam logic [ANG_W-1:0] WRAP_CRANK = ANG_W'(DEG_CRANK << FRAC_BITS);
    localparam logic [ANG_W-1:0] WRAP_CYCLE = ANG_W'(DEG_CYCLE << FRAC_BITS);
    // reset settings: crank reference, polarity high, all widths zero
    localparam logic [CFG_W-1:0] RST_CFG = CFG_W'(1) << (CFG_W - 2);

    typedef struct packed {
        ref_sel_e          ref_sel;
        logic              pol;
        logic [ANG_W-1:0]  high;
        logic [ANG_W-1:0]  low;
        logic [MISS_W-1:0] miss;
        logic [ANG_W-1:0]  gap;
        logic [ANG_W-1:0]  tdc;
    } cfg_t;

    typedef struct packed {
        logic tooth;
    } out_t;

    cfg_t             cfg_in;
    cfg_t             cfg_use;
    logic [CFG_W-1:0] cfg_use_vec;
    logic [CFG_W-1:0] held_cfg;
    logic [ANG_W-1:0] wrap_val;
    logic [ANG_W-1:0] ref_ang;
    logic             active;
    out_t             out_d, out_q;

    always_comb begin
        cfg_in.ref_sel = ref_sel_e'(cycle_ref_i);
        cfg_in.pol     = pol_high_i;
        cfg_in.high    = high_width_i;
        cfg_in.low     = low_width_i;
        cfg_in.miss    = gap_teeth_i;
        cfg_in.gap     = gap_start_i;
        cfg_in.tdc     = tdc_shift_i;
    end

    cwg_cfg_hold #(
        .ANG_W   (ANG_W),
        .CFG_W   (CFG_W),
        .RST_CFG (RST_CFG)
    ) i_cfg_hold (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .angle_i    (angle_i),
        .cfg_i      (cfg_in),
        .cfg_use_o  (cfg_use_vec),
        .cfg_held_o (held_cfg)
    );

    assign cfg_use  = cfg_t'(cfg_use_vec);
    assign wrap_val = (cfg_use.ref_sel == REF_CYCLE) ? WRAP_CYCLE : WRAP_CRANK;

    cwg_mod_sub #(.W(ANG_W)) i_tdc_sub (
        .a_i    (angle_i),
        .b_i    (cfg_use.tdc),
        .wrap_i (wrap_val),
        .diff_o (ref_ang)
    );

    cwg_tooth_map #(
        .ANG_W  (ANG_W),
        .MISS_W (MISS_W)
    ) i_tooth_map (
        .ref_ang_i   (ref_ang),
        .wrap_i      (wrap_val),
        .high_i      (cfg_use.high),
        .low_i       (cfg_use.low),
        .miss_i      (cfg_use.miss),
        .gap_start_i (cfg_use.gap),
        .active_o    (active)
    );

    always_comb begin
        out_d       = out_q;
        out_d.tooth = cfg_use.pol ? active : !active;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign tooth_o = out_q.tooth;
endmodule

// File: rtl/cwg_checker.sv
`timescale 1ns/1ps
module cwg_checker #(
    parameter int unsigned ANG_W  = 14,
    parameter int unsigned MISS_W = 8,
    localparam int unsigned CFG_W = 2 + 4 * ANG_W + MISS_W
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [ANG_W-1:0] angle_i,
    input logic             tooth_o,
    input logic [CFG_W-1:0] held_cfg
);
    logic             seen_q;
    logic [ANG_W-1:0] prev_q;
    logic             held_pol;
    logic [ANG_W:0]   held_period;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q <= 1'b0;
            prev_q <= '0;
        end else begin
            seen_q <= 1'b1;
            prev_q <= angle_i;
        end
    end

    assign held_pol    = held_cfg[CFG_W-2];
    assign held_period = {1'b0, held_cfg[CFG_W-3 -: ANG_W]}
                       + {1'b0, held_cfg[CFG_W-3-ANG_W -: ANG_W]};

    // R1
    reset_low_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (tooth_o == 1'b0));

    // R9
    cfg_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && angle_i >= prev_q) |=> $stable(held_cfg));

    // R3
    still_angle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && angle_i == prev_q) |=> $stable(tooth_o));

    // R10
    zero_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (held_period == '0) |-> (tooth_o == !held_pol));
endmodule

bind crank_wheel_gen cwg_checker #(
    .ANG_W  (ANG_W),
    .MISS_W (MISS_W)
) i_cwg_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .angle_i  (angle_i),
    .tooth_o  (tooth_o),
    .held_cfg (held_cfg)
);

// File: tb/test_crank_wheel_gen.sv
`timescale 1ns/1ps
module test_crank_wheel_gen;
    localparam int unsigned FRAC  = 4;
    localparam int unsigned MW    = 8;
    localparam int unsigned AW    = 10 + FRAC;
    localparam int unsigned SCALE = 1 << FRAC;

    typedef struct packed {
        logic        cyc;
        logic        pol;
        int unsigned hi;
        int unsigned lo;
        int unsigned miss;
        int unsigned gap;
        int unsigned tdc;
        int unsigned ang;
        logic        expv;
        int unsigned req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1,  6, 6, 2, 336,  0,   0, 1'b1,  2}, // R2 start of tooth
        '{1'b0, 1'b1,  6, 6, 2, 336,  0,   5, 1'b1,  2}, // R2 end of high phase
        '{1'b0, 1'b1,  6, 6, 2, 336,  0,   6, 1'b0,  2}, // R2 low phase start
        '{1'b0, 1'b1,  6, 6, 2, 336,  0,  11, 1'b0,  2}, // R2 low phase end
        '{1'b0, 1'b1,  6, 6, 2, 336,  0, 324, 1'b1,  4}, // R4 last tooth before gap
        '{1'b0, 1'b1,  6, 6, 2, 336,  0, 336, 1'b0,  4}, // R4 gap start
        '{1'b0, 1'b1,  6, 6, 2, 336,  0, 359, 1'b0,  4}, // R4 gap end
        '{1'b0, 1'b1,  6, 6, 0, 336,  0, 340, 1'b1, 11}, // R11 no gap
        '{1'b0, 1'b1,  6, 6, 2, 300,  0, 340, 1'b1,  5}, // R5 gap moved away
        '{1'b0, 1'b1,  6, 6, 2, 300,  0, 312, 1'b0,  5}, // R5 gap moved here
        '{1'b0, 1'b0,  6, 6, 2, 336,  0,   0, 1'b0,  6}, // R6 inverted high phase
        '{1'b0, 1'b0,  6, 6, 2, 336,  0,   6, 1'b1,  6}, // R6 inverted low phase
        '{1'b0, 1'b0,  6, 6, 2, 336,  0, 340, 1'b1,  6}, // R6 inverted gap
        '{1'b0, 1'b1,  6, 6, 2, 336,  3,   3, 1'b1,  7}, // R7 shifted tooth start
        '{1'b0, 1'b1,  6, 6, 2, 336,  3,   9, 1'b0,  7}, // R7 shifted low phase
        '{1'b0, 1'b1,  6, 6, 2, 336,  3,   8, 1'b1,  7}, // R7 shifted high end
        '{1'b0, 1'b1,  6, 6, 0, 336, 10,   0, 1'b1,  7}, // R7 shift wraps: ref 350
        '{1'b1, 1'b1,  6, 6, 1, 700,  0, 400, 1'b1,  8}, // R8 cycle angle past 360
        '{1'b1, 1'b1,  6, 6, 1, 700,  0, 705, 1'b0,  8}, // R8 gap near 720
        '{1'b1, 1'b1,  6, 6, 1, 700,  0, 712, 1'b1,  8}, // R8 first tooth after gap
        '{1'b0, 1'b1,  0, 0, 2, 336,  0, 100, 1'b0, 10}, // R10 zero period
        '{1'b0, 1'b0,  0, 0, 2, 336,  0, 100, 1'b1, 10}, // R10 zero period inverted
        '{1'b0, 1'b1, 10, 2, 0,   0,  0,   9, 1'b1,  2}, // R2 wide high phase
        '{1'b0, 1'b1, 10, 2, 0,   0,  0,  10, 1'b0,  2}  // R2 narrow low phase
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] angle = '0;
    logic          cyc = 1'b0;
    logic [AW-1:0] hi_w = '0;
    logic [AW-1:0] lo_w = '0;
    logic [MW-1:0] miss = '0;
    logic [AW-1:0] gap = '0;
    logic [AW-1:0] tdc = '0;
    logic          pol = 1'b1;
    logic          tooth;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    crank_wheel_gen #(.FRAC_BITS(FRAC), .MISS_W(MW)) i_crank_wheel_gen (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .angle_i      (angle),
        .cycle_ref_i  (cyc),
        .high_width_i (hi_w),
        .low_width_i  (lo_w),
        .gap_teeth_i  (miss),
        .gap_start_i  (gap),
        .tdc_shift_i  (tdc),
        .pol_high_i   (pol),
        .tooth_o      (tooth)
    );

    task automatic check(input logic act, input logic expv, input string tag);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: tooth_o=%b expected %b", tag, act, expv);
        end
    endtask

    task automatic step(input int unsigned deg);
        @(negedge clk);
        angle = AW'(deg * SCALE);
        @(posedge clk);
        #1;
    endtask

    // new settings, then a forced wrap (max angle, then 0), then the target
    task automatic apply(input vec_t v);
        @(negedge clk);
        cyc  = v.cyc;
        pol  = v.pol;
        hi_w = AW'(v.hi * SCALE);
        lo_w = AW'(v.lo * SCALE);
        miss = MW'(v.miss);
        gap  = AW'(v.gap * SCALE);
        tdc  = AW'(v.tdc * SCALE);
        angle = AW'((v.cyc ? 720 : 360) * SCALE - 1);
        @(posedge clk);
        step(0);
        step(v.ang);
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // settings that would give 1 at angle 0, applied while in reset
        cyc = 1'b0; pol = 1'b1; hi_w = AW'(6 * SCALE); lo_w = AW'(6 * SCALE);
        miss = '0; gap = '0; tdc = '0; angle = '0;
        repeat (3) @(posedge clk);
        #1;
        check(tooth, 1'b0, "R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R9: first edge after reset takes the input settings
        check(tooth, 1'b1, "R9 load at first edge after reset");

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check(tooth, VECS[i].expv, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R9: polarity change mid revolution waits for the wrap
        apply(VECS[0]);
        @(negedge clk);
        pol = 1'b0;
        angle = AW'(12 * SCALE);
        @(posedge clk);
        #1;
        check(tooth, 1'b1, "R9 settings held mid revolution");
        step(18);
        check(tooth, 1'b0, "R9 old polarity low phase");
        step(0);
        check(tooth, 1'b0, "R9 new polarity after wrap");

        // R3: output moves only at the clock edge
        @(negedge clk);
        angle = AW'(6 * SCALE);
        #1;
        check(tooth, 1'b0, "R3 no change before edge");
        @(posedge clk);
        #1;
        check(tooth, 1'b1, "R3 change after one edge");

        // R1: reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(tooth, 1'b0, "R1 reset clears output");
        @(negedge clk);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule